// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Scoped Invalidation

This block is the translation cache in front of an I/O memory management unit's page-table walker. It is fully associative. Each entry keeps a valid flag, an address-space identifier, a 20-bit virtual page number, a physical frame number and three permission bits. A client presents an address-space identifier and a 32-bit virtual address on the lookup port. One cycle later the block reports hit, frame and permissions. The walker installs translations through a refill port, which picks a free line or evicts one in round-robin order.

Software invalidates entries by writing one 32-bit command word to the invalidation port. The two low bits choose the scope: everything, one 4 MiB section or one 16 KiB group. Bit 31 can narrow the scope to a single address-space identifier. Where that identifier sits in the word depends on a configuration flag that selects a 4-identifier (narrow) or 128-identifier (wide) arrangement. A second configuration input limits how many lines take part in hits and refills.

Top module: `iommu_tlb`

## Requirements
- R1: A lookup is answered on the clock edge after the request. The hit output is 1 only when an entry is valid, lies in an active line, has an equal identifier and has a page number equal to address bits [31:12]. Bits [11:0] are ignored. On a hit, the frame and the permissions (bit 2 read, bit 1 write, bit 0 non-secure) of that entry are output. On a miss, or in a cycle with no request, hit, frame and permissions are all 0.
- R2: When several active valid entries match a lookup, the one with the lowest index supplies the result.
- R3: A refill is written to the lowest-index active line that is invalid once any invalidation in the same cycle has been applied.
- R4: When every active line is valid, a refill replaces the line named by a round-robin pointer, which is 0 after reset. The victim is the pointer value, or line 0 if the pointer is at or above the active count. After the replacement the pointer becomes victim+1, or 0 if that reaches the active count.
- R5: Command bits [1:0] select the scope. 0 invalidates every entry. 2 invalidates entries whose address bits [31:22] equal command bits [19:10]. 3 invalidates entries whose address bits [31:14] equal command bits [19:2]. 1 invalidates nothing.
- R6: When command bit 31 is 1, only entries whose identifier equals the command identifier are invalidated. In wide mode the command identifier is bits [30:24]. In narrow mode it is bits [30:29] and is compared with identifier bits [1:0].
- R7: In narrow mode (cfg_narrow_asid = 1), lookups compare only identifier bits [1:0]. Entries still store all 7 bits.
- R8: The active count is min(cfg_lines, ENTRIES). Lines at or above it never hit and are never refilled, but they keep their contents and hit again once the count is raised. With a count of 0, refills are dropped.
- R9: A lookup in the same cycle as an invalidation sees the state after the invalidation. A refill in the same cycle as an invalidation survives it. A lookup in the same cycle as a refill sees the contents from before the refill.
- R10: After reset, every entry is invalid and all lookup outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lines | input | CNT_W | Number of active lines (clamped to ENTRIES) |
| cfg_narrow_asid | input | 1 | 1: 4-identifier arrangement, 0: 128-identifier |
| lk_req | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Registered hit |
| lk_pfn | output | PFN_W | Registered physical frame number |
| lk_perm | output | 3 | Registered permissions {read, write, non-secure} |
| rf_req | input | 1 | Refill request |
| rf_asid | input | 7 | Refill identifier |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | 3 | Refill permissions {read, write, non-secure} |
| fl_req | input | 1 | Invalidation command strobe |
| fl_cmd | input | 32 | Invalidation command word |

## Verification
The cache is filled with a crafted set of tags. Some pairs share a 16 KiB group, others share only a 4 MiB section, some share a page but differ in identifier, and some identifiers differ only above bit 1. After every operation the bench sweeps lookups over all stored tags with the stored identifier, with identifier bit 0 flipped and with identifier bit 2 flipped. That sweep tells a section match from a group match, an identifier-restricted invalidation from a global one, and wide comparison from narrow comparison. Full-cache refills, duplicate tags, a shrunk or zero line count, and invalidation, refill and lookup issued in the same cycle separate eviction order, priority and same-cycle ordering. A bench model computes the expected result of every lookup.

// File: rtl/iommu_tlb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the ASID-tagged translation cache.
// Assumes 32-bit virtual addresses and 4 KiB pages.
package iommu_tlb_pkg;
    localparam int VA_W          = 32;
    localparam int PAGE_SHIFT    = 12;
    localparam int VPN_W         = VA_W - PAGE_SHIFT;
    localparam int SECTION_SHIFT = 22;
    localparam int GROUP_SHIFT   = 14;
    localparam int SECT_LO       = SECTION_SHIFT - PAGE_SHIFT;
    localparam int GRP_LO        = GROUP_SHIFT - PAGE_SHIFT;
    localparam int ASID_W        = 7;
    localparam int ASID_NARROW_W = 2;
    localparam int CMD_ASID_EN   = 31;
    localparam int CMD_WIDE_LO   = CMD_ASID_EN - ASID_W;
    localparam int CMD_NARROW_LO = CMD_ASID_EN - ASID_NARROW_W;

    typedef enum logic [1:0] {
        SCOPE_ALL     = 2'd0,
        SCOPE_NONE    = 2'd1,
        SCOPE_SECTION = 2'd2,
        SCOPE_GROUP   = 2'd3
    } inv_scope_e;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
    } tlb_tag_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ns;
    } tlb_perm_t;

    // Identifier compare mask for the selected arrangement.
    function automatic logic [ASID_W-1:0] asid_mask(input logic narrow);
        return narrow ? ASID_W'((1 << ASID_NARROW_W) - 1) : {ASID_W{1'b1}};
    endfunction
endpackage

// File: rtl/iommu_tlb_inv_decode.sv
`timescale 1ns/1ps
// Module: decodes one invalidation command word and produces a per-entry
// kill vector. Assumes the command fields described for the top module;
// scope value 1 is treated as "invalidate nothing".
module iommu_tlb_inv_decode
    import iommu_tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                 fl_req,
    input  logic [31:0]          fl_cmd,
    input  logic                 narrow,
    input  tlb_tag_t             tags [ENTRIES],
    output logic [ENTRIES-1:0]   kill
);
    inv_scope_e        scope;
    logic              asid_en;
    logic [ASID_W-1:0] cmd_asid;
    logic [ASID_W-1:0] mask;
    wire               unused_cmd = ^fl_cmd[23:20];

    // Field extraction from the command word.
    always_comb begin
        scope    = inv_scope_e'(fl_cmd[1:0]);
        asid_en  = fl_cmd[CMD_ASID_EN];
        mask     = asid_mask(narrow);
        cmd_asid = narrow ? ASID_W'(fl_cmd[CMD_ASID_EN-1:CMD_NARROW_LO])
                          : fl_cmd[CMD_ASID_EN-1:CMD_WIDE_LO];
    end

    // Per-entry scope and identifier match.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
        logic asid_ok;
        logic va_ok;
        always_comb begin
            asid_ok = !asid_en || ((tags[g].asid & mask) == cmd_asid);
            unique case (scope)
                SCOPE_ALL:     va_ok = 1'b1;
                SCOPE_SECTION: va_ok = tags[g].vpn[VPN_W-1:SECT_LO] == fl_cmd[VPN_W-1:SECT_LO];
                SCOPE_GROUP:   va_ok = tags[g].vpn[VPN_W-1:GRP_LO] == fl_cmd[VPN_W-1:GRP_LO];
                default:       va_ok = 1'b0;
            endcase
            kill[g] = fl_req && asid_ok && va_ok;
        end
    end
endmodule

// File: rtl/iommu_tlb_lookup.sv
`timescale 1ns/1ps
// Module: associative compare of all entries against a lookup, lowest
// index wins, result registered one cycle after the request. Assumes the
// valid vector given already folds in same-cycle invalidation and the
// active-line limit.
module iommu_tlb_lookup
    import iommu_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 narrow,
    input  logic                 lk_req,
    input  logic [ASID_W-1:0]    lk_asid,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [ENTRIES-1:0]   valid,
    input  tlb_tag_t             tags  [ENTRIES],
    input  logic [PFN_W-1:0]     pfns  [ENTRIES],
    input  tlb_perm_t            perms [ENTRIES],
    output logic                 hit,
    output logic [PFN_W-1:0]     pfn,
    output tlb_perm_t            perm
);
    logic [ASID_W-1:0] mask;
    logic              found;
    logic [PFN_W-1:0]  pfn_sel;
    tlb_perm_t         perm_sel;

    // Priority select: scan downwards so the lowest matching index remains.
    always_comb begin
        mask     = asid_mask(narrow);
        found    = 1'b0;
        pfn_sel  = '0;
        perm_sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid[i] && tags[i].vpn == lk_vpn &&
                (tags[i].asid & mask) == (lk_asid & mask)) begin
                found    = 1'b1;
                pfn_sel  = pfns[i];
                perm_sel = perms[i];
            end
        end
    end

    // Result register; zeros on miss or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit  <= 1'b0;
            pfn  <= '0;
            perm <= '0;
        end else begin
            hit  <= lk_req && found;
            pfn  <= (lk_req && found) ? pfn_sel : '0;
            perm <= (lk_req && found) ? perm_sel : '0;
        end
    end
endmodule

// File: rtl/iommu_tlb_victim.sv
`timescale 1ns/1ps
// Module: refill line selection. Lowest free active line first, otherwise
// a round-robin pointer over the active lines. Assumes the valid vector
// already reflects invalidation in the same cycle.
module iommu_tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = $clog2(ENTRIES + 1),
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rf_req,
    input  logic [ENTRIES-1:0]   valid,
    input  logic [ENTRIES-1:0]   active,
    input  logic [CNT_W-1:0]     lines,
    output logic                 fire,
    output logic [IDX_W-1:0]     idx
);
    logic [ENTRIES-1:0] free;
    logic               any_free;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   rr_q;
    logic [IDX_W-1:0]   rr_use;
    logic [CNT_W-1:0]   rr_next;

    // Lowest free active line.
    always_comb begin
        free     = ~valid & active;
        any_free = |free;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free[i]) free_idx = IDX_W'(i);
        end
    end

    // Round-robin victim and its successor, both kept inside the active range.
    always_comb begin
        rr_use  = (CNT_W'(rr_q) < lines) ? rr_q : '0;
        rr_next = CNT_W'(rr_use) + CNT_W'(1);
        if (rr_next >= lines) rr_next = '0;
        fire = rf_req && (lines != '0);
        idx  = any_free ? free_idx : rr_use;
    end

    // Pointer advances only on a replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)                rr_q <= '0;
        else if (fire && !any_free) rr_q <= IDX_W'(rr_next);
    end
endmodule

// File: rtl/iommu_tlb.sv
`timescale 1ns/1ps
// Module: ASID-tagged fully associative translation cache with a
// command-word invalidation port. Holds the entry storage; lookup,
// invalidation decode and refill selection live in submodules.
// Assumes ENTRIES >= 2. Order within a cycle: invalidate, then look up,
// then refill.
module iommu_tlb
    import iommu_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 20,
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_lines,
    input  logic                 cfg_narrow_asid,
    input  logic                 lk_req,
    input  logic [6:0]           lk_asid,
    input  logic [31:0]          lk_va,
    output logic                 lk_hit,
    output logic [PFN_W-1:0]     lk_pfn,
    output logic [2:0]           lk_perm,
    input  logic                 rf_req,
    input  logic [6:0]           rf_asid,
    input  logic [19:0]          rf_vpn,
    input  logic [PFN_W-1:0]     rf_pfn,
    input  logic [2:0]           rf_perm,
    input  logic                 fl_req,
    input  logic [31:0]          fl_cmd
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_q;
    tlb_tag_t           tag_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    tlb_perm_t          perm_q [ENTRIES];

    logic [CNT_W-1:0]   lines_eff;
    logic [ENTRIES-1:0] active;
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] valid_post;
    logic               rf_fire;
    logic [IDX_W-1:0]   rf_idx;
    tlb_perm_t          lk_perm_s;
    wire                unused_offset = ^lk_va[PAGE_SHIFT-1:0];

    // Active count clamped to the physical number of lines.
    always_comb begin
        lines_eff  = (cfg_lines > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : cfg_lines;
        valid_post = valid_q & ~kill;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_line
        // Line g takes part in hits and refills below the active count.
        assign active[g] = CNT_W'(g) < lines_eff;

        // Entry storage: a refill write wins over a same-cycle invalidation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                pfn_q[g]   <= '0;
                perm_q[g]  <= '0;
            end else if (rf_fire && rf_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= '{asid: rf_asid, vpn: rf_vpn};
                pfn_q[g]   <= rf_pfn;
                perm_q[g]  <= '{rd: rf_perm[2], wr: rf_perm[1], ns: rf_perm[0]};
            end else begin
                valid_q[g] <= valid_post[g];
            end
        end
    end

    iommu_tlb_inv_decode #(.ENTRIES(ENTRIES)) u_inv (
        .fl_req (fl_req),
        .fl_cmd (fl_cmd),
        .narrow (cfg_narrow_asid),
        .tags   (tag_q),
        .kill   (kill)
    );

    iommu_tlb_lookup #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .narrow  (cfg_narrow_asid),
        .lk_req  (lk_req),
        .lk_asid (lk_asid),
        .lk_vpn  (lk_va[VA_W-1:PAGE_SHIFT]),
        .valid   (valid_post & active),
        .tags    (tag_q),
        .pfns    (pfn_q),
        .perms   (perm_q),
        .hit     (lk_hit),
        .pfn     (lk_pfn),
        .perm    (lk_perm_s)
    );

    iommu_tlb_victim #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .rf_req (rf_req),
        .valid  (valid_post),
        .active (active),
        .lines  (lines_eff),
        .fire   (rf_fire),
        .idx    (rf_idx)
    );

    assign lk_perm = {lk_perm_s.rd, lk_perm_s.wr, lk_perm_s.ns};
endmodule

// File: rtl/iommu_tlb_chk.sv
`timescale 1ns/1ps
// Module: property checker for the translation cache, bound to its top.
// Observes ports and the storage valid vector and refill selection.
module iommu_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 20,
    parameter int CNT_W   = $clog2(ENTRIES + 1),
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_lines,
    input  logic                 lk_req,
    input  logic                 lk_hit,
    input  logic [PFN_W-1:0]     lk_pfn,
    input  logic [2:0]           lk_perm,
    input  logic                 rf_req,
    input  logic                 fl_req,
    input  logic [31:0]          fl_cmd,
    input  logic [ENTRIES-1:0]   valid_q,
    input  logic [ENTRIES-1:0]   active,
    input  logic [CNT_W-1:0]     lines_eff,
    input  logic                 rf_fire,
    input  logic [IDX_W-1:0]     rf_idx
);
    wire unused_cmd = ^fl_cmd[30:2];

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!lk_hit && lk_pfn == '0 && lk_perm == '0)); // R1

    AST_INV_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_cmd[1:0] == 2'd0 && !fl_cmd[31] && !rf_req) |=> valid_q == '0); // R5

    AST_INV_NONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_cmd[1:0] == 2'd1 && !rf_req) |=> $stable(valid_q)); // R5

    AST_REFILL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_fire |-> (CNT_W'(rf_idx) < lines_eff)); // R8

    AST_NO_LINES_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && cfg_lines == '0) |=> !lk_hit); // R8

    AST_REFILL_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_fire && !fl_req && |(~valid_q & active)) |-> !valid_q[rf_idx]); // R3

    AST_REFILL_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        rf_fire |=> valid_q[$past(rf_idx)]); // R9
endmodule

bind iommu_tlb iommu_tlb_chk #(
    .ENTRIES(ENTRIES), .PFN_W(PFN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_lines (cfg_lines),
    .lk_req    (lk_req),
    .lk_hit    (lk_hit),
    .lk_pfn    (lk_pfn),
    .lk_perm   (lk_perm),
    .rf_req    (rf_req),
    .fl_req    (fl_req),
    .fl_cmd    (fl_cmd),
    .valid_q   (valid_q),
    .active    (active),
    .lines_eff (lines_eff),
    .rf_fire   (rf_fire),
    .rf_idx    (rf_idx)
);

// File: tb/iommu_tlb_test.sv
`timescale 1ns/1ps
// Bench: drives the cache with crafted tag sets and compares every cycle's
// lookup outputs against a behavioural model written from the requirements.
module iommu_tlb_test;
    localparam int N = 8;
    localparam int PW = 20;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_lines = 4'd8;
    logic          cfg_narrow_asid = 1'b0;
    logic          lk_req = 0;
    logic [6:0]    lk_asid = 0;
    logic [31:0]   lk_va = 0;
    logic          lk_hit;
    logic [PW-1:0] lk_pfn;
    logic [2:0]    lk_perm;
    logic          rf_req = 0;
    logic [6:0]    rf_asid = 0;
    logic [19:0]   rf_vpn = 0;
    logic [PW-1:0] rf_pfn = 0;
    logic [2:0]    rf_perm = 0;
    logic          fl_req = 0;
    logic [31:0]   fl_cmd = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit         m_valid [N];
    logic [6:0] m_asid  [N];
    logic [19:0] m_vpn  [N];
    logic [PW-1:0] m_pfn [N];
    logic [2:0] m_perm  [N];
    int         m_rr;

    logic [6:0]  t_asid [8] = '{7'd3, 7'd3, 7'd3, 7'd9, 7'd3, 7'h45, 7'h7F, 7'd0};
    logic [19:0] t_vpn  [8] = '{20'h12340, 20'h12341, 20'h12344, 20'h12340,
                                20'h55000, 20'h55001, 20'hABCDE, 20'h00001};

    iommu_tlb #(.ENTRIES(N), .PFN_W(PW), .CNT_W(CW)) uut (.*);

    always #2 clk = ~clk;

    function automatic int lines_eff();
        return (int'(cfg_lines) > N) ? N : int'(cfg_lines);
    endfunction

    function automatic logic [6:0] amask();
        return cfg_narrow_asid ? 7'h03 : 7'h7F;
    endfunction

    task automatic m_flush(input logic [31:0] c);
        logic [6:0] a;
        a = cfg_narrow_asid ? {5'b0, c[30:29]} : c[30:24];
        for (int i = 0; i < N; i++) begin
            bit aok, vok;
            aok = !c[31] || ((m_asid[i] & amask()) == a);
            case (c[1:0])
                2'd0: vok = 1;
                2'd2: vok = (m_vpn[i][19:10] == c[19:10]);
                2'd3: vok = (m_vpn[i][19:2] == c[19:2]);
                default: vok = 0;
            endcase
            if (aok && vok) m_valid[i] = 0;
        end
    endtask

    task automatic m_refill(input logic [6:0] a, input logic [19:0] v,
                            input logic [PW-1:0] p, input logic [2:0] pm);
        int le, pick;
        le = lines_eff();
        if (le == 0) return;
        pick = -1;
        for (int i = le - 1; i >= 0; i--) if (!m_valid[i]) pick = i;
        if (pick < 0) begin
            pick = (m_rr < le) ? m_rr : 0;
            m_rr = (pick + 1 >= le) ? 0 : pick + 1;
        end
        m_valid[pick] = 1; m_asid[pick] = a; m_vpn[pick] = v;
        m_pfn[pick] = p; m_perm[pick] = pm;
    endtask

    // One cycle: invalidate, look up, refill. Called at a falling edge.
    task automatic step(input bit dl, input logic [6:0] la, input logic [31:0] va,
                        input bit dr, input logic [6:0] ra, input logic [19:0] rv,
                        input logic [PW-1:0] rp, input logic [2:0] rpm,
                        input bit df, input logic [31:0] fc, input string tag);
        bit e_hit; logic [PW-1:0] e_pfn; logic [2:0] e_perm;
        lk_req = dl; lk_asid = la; lk_va = va;
        rf_req = dr; rf_asid = ra; rf_vpn = rv; rf_pfn = rp; rf_perm = rpm;
        fl_req = df; fl_cmd = fc;
        if (df) m_flush(fc);
        e_hit = 0; e_pfn = 0; e_perm = 0;
        if (dl) begin
            for (int i = lines_eff() - 1; i >= 0; i--)
                if (m_valid[i] && m_vpn[i] == va[31:12] &&
                    (m_asid[i] & amask()) == (la & amask())) begin
                    e_hit = 1; e_pfn = m_pfn[i]; e_perm = m_perm[i];
                end
        end
        if (dr) m_refill(ra, rv, rp, rpm);
        @(posedge clk);
        @(negedge clk);
        lk_req = 0; rf_req = 0; fl_req = 0;
        checks++;
        if (lk_hit !== e_hit || lk_pfn !== e_pfn || lk_perm !== e_perm) begin
            errors++;
            $display("FAIL %s asid=%h va=%h: got hit=%b pfn=%h perm=%b, expected hit=%b pfn=%h perm=%b",
                     tag, la, va, lk_hit, lk_pfn, lk_perm, e_hit, e_pfn, e_perm);
        end
    endtask

    task automatic lk(input logic [6:0] a, input logic [31:0] va, input string tag);
        step(1, a, va, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rf(input logic [6:0] a, input logic [19:0] v,
                      input logic [PW-1:0] p, input logic [2:0] pm, input string tag);
        step(0, 0, 0, 1, a, v, p, pm, 0, 0, tag);
    endtask

    task automatic fl(input logic [31:0] c, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, c, tag);
    endtask

    task automatic fill_set(input string tag);
        for (int i = 0; i < 8; i++)
            rf(t_asid[i], t_vpn[i], 20'hF0000 | PW'(i * 20'h111), 3'(i), tag);
    endtask

    // Lookup sweep: stored tags with own identifier, bit 0 flipped, bit 2 flipped.
    task automatic sweep(input string tag);
        for (int i = 0; i < N; i++) begin
            lk(m_asid[i], {m_vpn[i], 12'hABC}, tag);
            lk(m_asid[i] ^ 7'h01, {m_vpn[i], 12'h000}, tag);
            lk(m_asid[i] ^ 7'h04, {m_vpn[i], 12'hFFF}, tag);
        end
        for (int i = 0; i < 8; i++) lk(t_asid[i], {t_vpn[i], 12'h123}, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
        end
        m_rr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (lk_hit !== 0 || lk_pfn !== 0 || lk_perm !== 0) begin
            errors++;
            $display("FAIL R10 reset outputs: got %b %h %b, expected 0 0 0", lk_hit, lk_pfn, lk_perm);
        end
        rst_n = 1;
        sweep("R10");

        // Basic fill and lookups.
        fill_set("R1");
        sweep("R1");
        // Full cache: round-robin replacement of lines 0 and 1.
        rf(7'd2, 20'h77770, 20'h0AAAA, 3'b110, "R4");
        rf(7'd2, 20'h77771, 20'h0BBBB, 3'b101, "R4");
        sweep("R4");
        lk(7'd2, {20'h77770, 12'h0}, "R4");
        lk(7'd2, {20'h77771, 12'h0}, "R4");
        // Duplicate tag in line 2: line 0 must still win.
        rf(7'd2, 20'h77770, 20'h0CCCC, 3'b011, "R2");
        lk(7'd2, {20'h77770, 12'h0}, "R2");
        sweep("R2");

        // Invalidation scopes.
        fl(32'h0000_0000, "R5");
        sweep("R5");
        fill_set("R3");
        sweep("R3");
        fl(32'h8000_0000 | (32'd3 << 24) | (32'h48 << 10) | 32'd2, "R6");
        sweep("R6");
        rf(t_asid[0], t_vpn[0], 20'h10000, 3'b111, "R3");
        rf(t_asid[1], t_vpn[1], 20'h10001, 3'b111, "R3");
        rf(t_asid[2], t_vpn[2], 20'h10002, 3'b111, "R3");
        sweep("R3");
        fl(32'h0001_2343, "R5");
        sweep("R5");
        fl(32'h0001_2341, "R5");
        sweep("R5");
        fill_set("R3");
        fl(32'h8000_0000 | (32'd3 << 24), "R6");
        sweep("R6");
        fl(32'h8000_0000 | (32'h45 << 24), "R6");
        sweep("R6");

        // Narrow identifier arrangement.
        fl(32'h0, "R5");
        cfg_narrow_asid = 1;
        fill_set("R7");
        sweep("R7");
        fl(32'h8000_0000 | (32'b01 << 29) | (32'b00011 << 24), "R6");
        sweep("R6");
        cfg_narrow_asid = 0;
        sweep("R7");

        // Active line count.
        fl(32'h0, "R5");
        fill_set("R8");
        cfg_lines = 4'd4;
        sweep("R8");
        rf(7'd5, 20'h99990, 20'h0DDDD, 3'b100, "R8");
        sweep("R8");
        cfg_lines = 4'd8;
        sweep("R8");
        cfg_lines = 4'd0;
        rf(7'd6, 20'h88880, 20'h0EEEE, 3'b010, "R8");
        lk(7'd6, {20'h88880, 12'h0}, "R8");
        cfg_lines = 4'd15;
        lk(7'd6, {20'h88880, 12'h0}, "R8");
        sweep("R8");

        // Same-cycle ordering.
        step(1, m_asid[4], {m_vpn[4], 12'h0}, 0, 0, 0, 0, 0, 1, 32'h0, "R9");
        step(0, 0, 0, 1, 7'd1, 20'h31415, 20'h02718, 3'b111, 1, 32'h0, "R9");
        lk(7'd1, {20'h31415, 12'h0}, "R9");
        step(1, 7'd4, {20'h27182, 12'h0}, 1, 7'd4, 20'h27182, 20'h01618, 3'b001, 0, 0, "R9");
        lk(7'd4, {20'h27182, 12'h0}, "R9");
        sweep("R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule